// File: doc/BRIEF.md
# Block Memory Transfer Engine

This block carries out one block-move instruction. It takes a 16-bit source address, a 16-bit destination address, a 16-bit byte count, a stepping mode, and the current stack pointer with the three index and accumulator registers. It then copies bytes one at a time over a simple synchronous memory bus. Each byte is read and then written, and the two addresses step according to the mode.

Before the first byte moves, the engine saves three registers into the stack page. It does not change the stack pointer. A start/busy/done handshake brackets the whole operation. An elapsed-cycle output reports the cost charged for the bytes copied so far, so the surrounding core can account time. Instruction fetch and decode are done elsewhere.

Top module: `blk_xfer_engine`

## Requirements
- R1: A `start` seen while `busy` is low captures all operands and raises `busy` on the next cycle. A `start` seen while `busy` is high is ignored and does not change the operation in progress.
- R2: Before any read, three writes go out in this order: `reg_y` to 0x0100|((sp-1) mod 256), then `reg_a` to 0x0100|((sp-2) mod 256), then `reg_x` to 0x0100|((sp-3) mod 256).
- R3: Each byte is read from the source address in one cycle (`mem_req`=1, `mem_we`=0). In the next cycle the same byte is written to the destination address (`mem_req`=1, `mem_we`=1). Read data is valid in the cycle after the read request.
- R4: Mode code 0 increments both the source and the destination address by one after each byte.
- R5: Mode code 1 decrements both the source and the destination address by one after each byte.
- R6: Mode code 2 increments the source address. The destination address stays fixed.
- R7: Mode code 3 increments the source address. The destination steps +1, -1, +1, … and starts with +1.
- R8: Mode code 4 steps the source +1, -1, +1, … and starts with +1. The destination address increments.
- R9: A length of 0 copies 65536 bytes. Any other length N copies exactly N bytes.
- R10: Source and destination addresses wrap modulo 65536.
- R11: `elapsed_cycles` is cleared when an operation is accepted and rises by 6 per byte copied. It holds its value after completion.
- R12: `busy` stays high for exactly 3+2N cycles. `done` is high for exactly one cycle, right after the last write, with `busy` low.
- R13: Mode codes 5, 6 and 7 behave like mode code 0.
- R14: After reset, `busy`, `done`, `mem_req` are low and `elapsed_cycles` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a new block move |
| mode | input | 3 | Stepping mode code |
| src_addr | input | 16 | First source address |
| dst_addr | input | 16 | First destination address |
| length | input | 16 | Byte count, 0 meaning 65536 |
| stack_ptr | input | 8 | Current stack pointer |
| reg_a | input | 8 | Accumulator value to save |
| reg_x | input | 8 | X index value to save |
| reg_y | input | 8 | Y index value to save |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| elapsed_cycles | output | 20 | Cycles charged for the bytes copied |
| mem_req | output | 1 | Bus access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read |

## Verification
The assertions check several properties on every cycle:
- every read is followed at once by a write;
- `done` lasts one cycle and never overlaps `busy`;
- an accepted start raises `busy` and clears the elapsed count;
- a fixed destination does not move;
- an alternating address changes on every step.

Some behaviours can only be shown by the bench's scenarios. These are the exact address sequences for each mode, the register save order and locations (including stack pointer wrap), the wrap-around of addresses at the top of memory, the 65536-byte case, and the fact that a start arriving mid-copy leaves the copy untouched.

// File: rtl/blk_xfer_pkg.sv
// Shared types for the block memory transfer engine.
// Assumes: mode codes 0..4 are defined; other codes fall back to code 0.
package blk_xfer_pkg;

    typedef enum logic [1:0] {
        STEP_INC  = 2'd0,
        STEP_DEC  = 2'd1,
        STEP_HOLD = 2'd2,
        STEP_ALT  = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SAVE = 2'd1,
        PH_READ = 2'd2,
        PH_WRITE = 2'd3
    } phase_e;

    localparam logic [2:0] MODE_UP_UP     = 3'd0;
    localparam logic [2:0] MODE_DN_DN     = 3'd1;
    localparam logic [2:0] MODE_UP_FIX    = 3'd2;
    localparam logic [2:0] MODE_UP_SWING  = 3'd3;
    localparam logic [2:0] MODE_SWING_UP  = 3'd4;

    // Source stepping rule for a mode code.
    function automatic step_e src_rule(input logic [2:0] m);
        case (m)
            MODE_DN_DN:    return STEP_DEC;
            MODE_SWING_UP: return STEP_ALT;
            default:       return STEP_INC;
        endcase
    endfunction

    // Destination stepping rule for a mode code.
    function automatic step_e dst_rule(input logic [2:0] m);
        case (m)
            MODE_DN_DN:    return STEP_DEC;
            MODE_UP_FIX:   return STEP_HOLD;
            MODE_UP_SWING: return STEP_ALT;
            default:       return STEP_INC;
        endcase
    endfunction

endpackage

// File: rtl/xfer_addr_step.sv
// Address register with a selectable stepping rule.
// Assumes: load and advance are never high together; the rule stays
// constant between a load and the end of the operation.
module xfer_addr_step
    import blk_xfer_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  step_e         rule,
    input  logic          advance,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] ONE = AW'(1);

    logic backward;       // alternating rule: next step is -1
    logic [AW-1:0] next_addr;

    // Next address from the current rule and alternation phase.
    always_comb begin
        case (rule)
            STEP_INC:  next_addr = addr + ONE;
            STEP_DEC:  next_addr = addr - ONE;
            STEP_HOLD: next_addr = addr;
            default:   next_addr = backward ? (addr - ONE) : (addr + ONE);
        endcase
    end

    // Address and alternation phase registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr     <= '0;
            backward <= 1'b0;
        end else if (load) begin
            addr     <= load_addr;
            backward <= 1'b0;
        end else if (advance) begin
            addr <= next_addr;
            if (rule == STEP_ALT)
                backward <= ~backward;
        end
    end

    // R6: a held address does not move when stepped
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && rule == STEP_HOLD) |=> addr == $past(addr));

    // R7 / R8: an alternating address changes on every step
    a_r7_swing_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && rule == STEP_ALT) |=> addr != $past(addr));

endmodule

// File: rtl/xfer_seq.sv
// Sequencer for the transfer: idle, three register saves, then
// read/write pairs until the last byte.
// Assumes: last_byte is valid during the write phase.
module xfer_seq
    import blk_xfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       last_byte,
    output phase_e     phase,
    output logic [1:0] save_idx,
    output logic       accept,
    output logic       advance,
    output logic       busy,
    output logic       done
);

    localparam logic [1:0] SAVE_LAST = 2'd2;

    assign accept  = (phase == PH_IDLE) && start;
    assign advance = (phase == PH_WRITE);
    assign busy    = (phase != PH_IDLE);

    // Phase, save counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            save_idx <= 2'd0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: if (start) begin
                    phase    <= PH_SAVE;
                    save_idx <= 2'd0;
                end
                PH_SAVE: if (save_idx == SAVE_LAST)
                    phase <= PH_READ;
                else
                    save_idx <= save_idx + 2'd1;
                PH_READ: phase <= PH_WRITE;
                default: if (last_byte) begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                end else begin
                    phase <= PH_READ;
                end
            endcase
        end
    end

    // R2: register saves always lead into the first read
    a_r2_save_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SAVE && save_idx == SAVE_LAST) |=> phase == PH_READ);

endmodule

// File: rtl/blk_xfer_engine.sv
// Block memory transfer engine top: captures operands, saves three
// registers into the stack page, then copies bytes with per-mode address
// stepping and charges a fixed cycle cost per byte.
// Assumes: the memory returns read data the cycle after a read request
// and accepts a write in the cycle it is requested.
module blk_xfer_engine
    import blk_xfer_pkg::*;
#(
    parameter int AW           = 16,
    parameter int DW           = 8,
    parameter int LW           = 16,
    parameter int SPW          = 8,
    parameter int CW           = 20,
    parameter int COST_PER_BYTE = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [LW-1:0] length,
    input  logic [SPW-1:0] stack_ptr,
    input  logic [DW-1:0] reg_a,
    input  logic [DW-1:0] reg_x,
    input  logic [DW-1:0] reg_y,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] elapsed_cycles,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    localparam int RW = LW + 1;
    localparam logic [RW-1:0] FULL_LEN = RW'(1) << LW;
    localparam logic [AW-SPW-1:0] STACK_PAGE = (AW-SPW)'(1);
    localparam logic [CW-1:0] COST = CW'(COST_PER_BYTE);

    phase_e         phase;
    logic [1:0]     save_idx;
    logic           accept, advance;
    logic [2:0]     mode_q;
    logic [SPW-1:0] sp_q;
    logic [DW-1:0]  a_q, x_q, y_q;
    logic [RW-1:0]  remaining;
    logic [AW-1:0]  src_cur, dst_cur;
    logic [SPW-1:0] save_slot;
    step_e          src_kind, dst_kind;

    assign src_kind = src_rule(mode_q);
    assign dst_kind = dst_rule(mode_q);

    xfer_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .last_byte (remaining == RW'(1)),
        .phase     (phase),
        .save_idx  (save_idx),
        .accept    (accept),
        .advance   (advance),
        .busy      (busy),
        .done      (done)
    );

    xfer_addr_step #(.AW(AW)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_addr (src_addr),
        .rule      (src_kind),
        .advance   (advance),
        .addr      (src_cur)
    );

    xfer_addr_step #(.AW(AW)) u_dst (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_addr (dst_addr),
        .rule      (dst_kind),
        .advance   (advance),
        .addr      (dst_cur)
    );

    // Operand capture, byte countdown and elapsed-cycle accounting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q         <= '0;
            sp_q           <= '0;
            a_q            <= '0;
            x_q            <= '0;
            y_q            <= '0;
            remaining      <= '0;
            elapsed_cycles <= '0;
        end else if (accept) begin
            mode_q         <= mode;
            sp_q           <= stack_ptr;
            a_q            <= reg_a;
            x_q            <= reg_x;
            y_q            <= reg_y;
            remaining      <= (length == '0) ? FULL_LEN : RW'(length);
            elapsed_cycles <= '0;
        end else if (advance) begin
            remaining      <= remaining - RW'(1);
            elapsed_cycles <= elapsed_cycles + COST;
        end
    end

    assign save_slot = sp_q - SPW'(save_idx) - SPW'(1);

    // Bus drive for the current phase.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (phase)
            PH_SAVE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {STACK_PAGE, save_slot};
                case (save_idx)
                    2'd0:    mem_wdata = y_q;
                    2'd1:    mem_wdata = a_q;
                    default: mem_wdata = x_q;
                endcase
            end
            PH_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_cur;
            end
            PH_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_cur;
                mem_wdata = mem_rdata;
            end
            default: ;
        endcase
    end

    // R1: an accepted start makes the engine busy
    a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R11: the elapsed count is zero right after acceptance
    a_r11_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> elapsed_cycles == '0);

    // R3: every read is followed immediately by a write
    a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> (mem_req && mem_we));

    // R12: done lasts a single cycle
    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: done never overlaps busy or bus activity
    a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mem_req));

endmodule

// File: tb/tb_blk_xfer_engine.sv
module tb_blk_xfer_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [15:0] src_addr = '0, dst_addr = '0, length = '0;
    logic [7:0]  stack_ptr = '0, reg_a = '0, reg_x = '0, reg_y = '0;
    logic        busy, done, mem_req, mem_we;
    logic [19:0] elapsed_cycles;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;   // 125 MHz

    blk_xfer_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .src_addr(src_addr), .dst_addr(dst_addr), .length(length),
        .stack_ptr(stack_ptr), .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y),
        .busy(busy), .done(done), .elapsed_cycles(elapsed_cycles),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory content is a pure function of the address.
    function automatic logic [7:0] mem_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // Synchronous read model: data valid in the cycle after the request.
    always @(posedge clk)
        if (mem_req && !mem_we) mem_rdata <= mem_val(mem_addr);

    // Step kinds: 0 inc, 1 dec, 2 hold, 3 alternate.
    function automatic int src_kind_of(input logic [2:0] m);
        case (m)
            3'd1: return 1;
            3'd4: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int dst_kind_of(input logic [2:0] m);
        case (m)
            3'd1: return 1;
            3'd2: return 2;
            3'd3: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] step(input logic [15:0] a, input int k, input bit back);
        case (k)
            0: return a + 16'd1;
            1: return a - 16'd1;
            2: return a;
            default: return back ? a - 16'd1 : a + 16'd1;
        endcase
    endfunction

    // Bus monitor model state.
    bit          m_on = 0;
    int          m_saves, m_bytes, m_err, m_sk, m_dk;
    bit          m_sb, m_db, m_have_rd;
    logic [15:0] m_src, m_dst, m_rd;
    logic [7:0]  m_sp, m_a, m_x, m_y;
    logic [15:0] bad_addr, bad_exp;

    task automatic note_bad(input logic [15:0] act, input logic [15:0] exp);
        if (m_err == 0) begin bad_addr = act; bad_exp = exp; end
        m_err++;
    endtask

    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (!m_on) begin
                note_bad(mem_addr, 16'hxxxx);
            end else if (m_saves < 3) begin
                logic [15:0] ea;
                logic [7:0]  ed;
                ea = {8'h01, m_sp - 8'(m_saves) - 8'd1};
                ed = (m_saves == 0) ? m_y : (m_saves == 1) ? m_a : m_x;
                if (!mem_we || mem_addr != ea || mem_wdata != ed) note_bad(mem_addr, ea);
                m_saves++;
            end else if (!mem_we) begin
                if (mem_addr != m_src) note_bad(mem_addr, m_src);
                m_rd = m_src;
                m_have_rd = 1;
                m_src = step(m_src, m_sk, m_sb);
                if (m_sk == 3) m_sb = ~m_sb;
            end else begin
                if (!m_have_rd || mem_addr != m_dst || mem_wdata != mem_val(m_rd))
                    note_bad(mem_addr, m_dst);
                m_have_rd = 0;
                m_dst = step(m_dst, m_dk, m_db);
                if (m_dk == 3) m_db = ~m_db;
                m_bytes++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one transfer and check its bus sequence, count, cost and timing.
    // poke: drive a conflicting start during the copy.
    task automatic run_xfer(input logic [2:0] md, input logic [15:0] s, input logic [15:0] d,
                            input logic [15:0] len, input logic [7:0] sp, input bit poke,
                            input string tag);
        int nb, busy_cnt;
        bit saw_done;
        nb = (len == 0) ? 65536 : int'(len);
        @(negedge clk);
        mode = md; src_addr = s; dst_addr = d; length = len; stack_ptr = sp;
        reg_a = 8'($urandom); reg_x = 8'($urandom); reg_y = 8'($urandom);
        m_on = 1; m_saves = 0; m_bytes = 0; m_err = 0; m_have_rd = 0;
        m_src = s; m_dst = d; m_sb = 0; m_db = 0;
        m_sk = src_kind_of(md); m_dk = dst_kind_of(md);
        m_sp = sp; m_a = reg_a; m_x = reg_x; m_y = reg_y;
        start = 1;
        @(negedge clk);
        start = 0;
        busy_cnt = 0; saw_done = 0;
        for (int t = 0; t < 140000; t++) begin
            if (done) begin saw_done = 1; break; end
            if (busy) busy_cnt++;
            if (poke && t == 4) begin
                start = 1; src_addr = ~s; dst_addr = ~d; length = 16'd3;
                mode = md + 3'd1; stack_ptr = ~sp; reg_a = ~reg_a;
            end else if (poke && t == 5) begin
                start = 0;
            end
            @(negedge clk);
        end
        check(saw_done && !busy, {tag, " R12 done pulse"}, int'(saw_done), 1);
        check(busy_cnt == 3 + 2 * nb, {tag, " R12 busy length"}, busy_cnt, 3 + 2 * nb);
        check(m_err == 0, {tag, " R2/R3 bus sequence"}, int'(bad_addr), int'(bad_exp));
        check(m_bytes == nb, {tag, " R9 byte count"}, m_bytes, nb);
        check(int'(elapsed_cycles) == 6 * nb, {tag, " R11 elapsed"}, int'(elapsed_cycles), 6 * nb);
        @(negedge clk);
        check(!done && !busy, {tag, " R12 done single"}, int'(done), 0);
        check(int'(elapsed_cycles) == 6 * nb, {tag, " R11 hold"}, int'(elapsed_cycles), 6 * nb);
        m_on = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 180000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<180000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!busy && !done && !mem_req && elapsed_cycles == 0, "R14 reset state",
              int'(busy) + int'(done) + int'(mem_req), 0);

        // Directed corner cases.
        run_xfer(3'd0, 16'h1000, 16'h2000, 16'd5, 8'hF0, 0, "R4 up/up");
        run_xfer(3'd1, 16'h3005, 16'h4005, 16'd6, 8'h10, 0, "R5 down/down");
        run_xfer(3'd2, 16'h0500, 16'h0900, 16'd7, 8'h80, 0, "R6 up/fixed");
        run_xfer(3'd3, 16'h0600, 16'h0A00, 16'd8, 8'h42, 0, "R7 up/swing");
        run_xfer(3'd4, 16'h0700, 16'h0B00, 16'd8, 8'h33, 0, "R8 swing/up");
        run_xfer(3'd0, 16'hFFFE, 16'hFFFD, 16'd5, 8'h00, 0, "R10 wrap up, sp wrap R2");
        run_xfer(3'd1, 16'h0001, 16'h0002, 16'd5, 8'h02, 0, "R10 wrap down");
        run_xfer(3'd1, 16'h0000, 16'h0000, 16'd1, 8'h01, 0, "R9 single byte");
        run_xfer(3'd6, 16'h1230, 16'h4560, 16'd4, 8'h77, 0, "R13 code 6");
        run_xfer(3'd7, 16'h1230, 16'h4560, 16'd3, 8'h78, 0, "R13 code 7");
        run_xfer(3'd0, 16'h2000, 16'h3000, 16'd9, 8'h55, 1, "R1 start ignored while busy");

        // Constrained random transfers.
        for (int i = 0; i < 30; i++) begin
            run_xfer(3'($urandom_range(0, 7)), 16'($urandom), 16'($urandom),
                     16'($urandom_range(1, 24)), 8'($urandom), i[0], "R4-R8 random");
        end

        // Zero length means the full 64 KiB.
        run_xfer(3'd3, 16'h8000, 16'h1000, 16'd0, 8'hFF, 0, "R9 length zero");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule